// File: doc/BRIEF.md
# ROM Program Sequencer

This block steps a tiny calculating machine through a program of sixteen words held in ROM. It keeps the instruction pointer, which drives the ROM address. It sorts each fetched word into one of four classes: arithmetic (ALU), register move (MOV), jump (JMP) and halt (HLT). It enables register-file writes for the classes that produce data. It also keeps the carry and zero flags, which supply the ALU carry input and decide the conditional jumps.

The ROM is read combinationally. The word at `rom_addr` shows on `instr` in the same cycle, and the ALU result flags show on `alu_carry` and `alu_zero`. On each rising clock edge the pointer advances, reloads from a jump, or freezes. The flags take the ALU outputs only when an ALU word is executing. A halt word makes the sequencer freeze on itself, and only reset ends that state.

Top module: `rom_sequencer`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) clears the pointer to 0 and clears both flags. After release, the halt state is cleared.
- R2: The class is `instr[7:6]`: 00 ALU, 01 MOV, 10 JMP, 11 HLT. Exactly one of `is_alu`, `is_mov`, `is_jmp`, `is_hlt` is high in every cycle. While halted, only `is_hlt` is high.
- R3: On an ALU or MOV word the pointer increments by one at the clock edge, wrapping from 15 to 0.
- R4: The jump kind is `instr[5:4]`. Kind 00 always jumps: the pointer loads the target `instr[3:0]`.
- R5: Kind 01 loads the target when the stored carry flag is 1. Otherwise the pointer increments.
- R6: Kind 10 loads the target when the stored zero flag is 1. Otherwise the pointer increments.
- R7: Kind 11 never jumps, and the pointer increments.
- R8: On an ALU word, `flag_c` and `flag_z` take `alu_carry` and `alu_zero` at the clock edge.
- R9: On MOV, JMP and HLT words both flags keep their value, whatever `alu_carry` and `alu_zero` carry.
- R10: `alu_cin` always equals the stored carry flag.
- R11: A HLT word holds the pointer at its own address. From then on, no word changes the pointer or the flags until reset.
- R12: `reg_we` is high for ALU and MOV words and low for JMP words and while halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 8 | Program word read at `rom_addr` |
| alu_carry | input | 1 | Carry out of the ALU for the current word |
| alu_zero | input | 1 | Zero result indication from the ALU |
| rom_addr | output | 4 | Instruction pointer, ROM address |
| is_alu | output | 1 | Current word is an arithmetic operation |
| is_mov | output | 1 | Current word is a register move |
| is_jmp | output | 1 | Current word is a jump |
| is_hlt | output | 1 | Halt word or halted state |
| reg_we | output | 1 | Register-file write enable |
| alu_cin | output | 1 | Carry input to the ALU |
| flag_c | output | 1 | Stored carry flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The assertions assume that `instr`, `alu_carry` and `alu_zero` are settled before each rising edge and hold steady across it, as a combinational ROM and ALU would provide. The bench changes these inputs only on falling edges and samples results on the following falling edge, so every word is stable around the edge that consumes it. It also asserts reset on a falling edge, so the asynchronous clear never lands at an active edge. Each program word the bench applies is built from the field layout stated in the requirements, so every jump kind and class code is reached on purpose.

// File: rtl/rom_seq_pkg.sv
package rom_seq_pkg;

   typedef enum logic [1:0] {
      CLS_ALU = 2'b00,
      CLS_MOV = 2'b01,
      CLS_JMP = 2'b10,
      CLS_HLT = 2'b11
   } op_class_e;

   typedef enum logic [1:0] {
      JK_ALWAYS = 2'b00,
      JK_CARRY  = 2'b01,
      JK_ZERO   = 2'b10,
      JK_NEVER  = 2'b11
   } jump_kind_e;

   localparam int unsigned CLASS_W = 2;
   localparam int unsigned KIND_W  = 2;
   localparam int unsigned FLAG_C  = 0;
   localparam int unsigned FLAG_Z  = 1;
   localparam int unsigned N_FLAGS = 2;

endpackage

// File: rtl/rom_seq_decode.sv
module rom_seq_decode
   import rom_seq_pkg::*;
#(
   parameter int unsigned IW = 8,
   parameter int unsigned AW = 4
) (
   input  logic [IW-1:0] instr,
   output op_class_e     op_class,
   output jump_kind_e    jump_kind,
   output logic [AW-1:0] target
);

   localparam int unsigned CLS_LSB  = IW - CLASS_W;
   localparam int unsigned KIND_LSB = AW;

   generate
      if (CLS_LSB < KIND_LSB + KIND_W) begin : g_bad_layout
         $error("rom_seq_decode: IW too narrow for class, kind and target fields");
      end
   endgenerate

   always_comb begin
      op_class  = op_class_e'(instr[CLS_LSB +: CLASS_W]);
      jump_kind = jump_kind_e'(instr[KIND_LSB +: KIND_W]);
      target    = instr[AW-1:0];
   end

endmodule

// File: rtl/rom_seq_flags.sv
module rom_seq_flags #(
   parameter int unsigned NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [NF-1:0] flag_d,
   output logic [NF-1:0] flag_q
);

   generate
      if (NF < 1) begin : g_bad_nf
         $error("rom_seq_flags: NF must be at least 1");
      end
      for (genvar i = 0; i < NF; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q[i] <= 1'b0;
            end else if (cap_en) begin
               flag_q[i] <= flag_d[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rom_seq_ptr.sv
module rom_seq_ptr #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hlt_word,
   input  logic          take,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] ip,
   output logic          halted
);

   localparam logic [AW-1:0] ONE = AW'(1);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("rom_seq_ptr: AW must be at least 1");
      end
   endgenerate

   logic          freeze;
   logic [AW-1:0] ip_nxt;

   always_comb begin
      freeze = halted | hlt_word;
      if (freeze) begin
         ip_nxt = ip;
      end else if (take) begin
         ip_nxt = target;
      end else begin
         ip_nxt = ip + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip     <= '0;
         halted <= 1'b0;
      end else begin
         ip     <= ip_nxt;
         halted <= freeze;
      end
   end

endmodule

// File: rtl/rom_sequencer.sv
module rom_sequencer
   import rom_seq_pkg::*;
#(
   parameter int unsigned IW = 8,
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] instr,
   input  logic          alu_carry,
   input  logic          alu_zero,
   output logic [AW-1:0] rom_addr,
   output logic          is_alu,
   output logic          is_mov,
   output logic          is_jmp,
   output logic          is_hlt,
   output logic          reg_we,
   output logic          alu_cin,
   output logic          flag_c,
   output logic          flag_z
);

   op_class_e            op_class;
   jump_kind_e           jump_kind;
   logic [AW-1:0]        target;
   logic                 halted;
   logic                 take;
   logic [N_FLAGS-1:0]   flag_d;
   logic [N_FLAGS-1:0]   flag_q;

   rom_seq_decode #(.IW(IW), .AW(AW)) dec_i (
      .instr     (instr),
      .op_class  (op_class),
      .jump_kind (jump_kind),
      .target    (target)
   );

   always_comb begin
      is_alu = !halted && (op_class == CLS_ALU);
      is_mov = !halted && (op_class == CLS_MOV);
      is_jmp = !halted && (op_class == CLS_JMP);
      is_hlt =  halted || (op_class == CLS_HLT);
      reg_we = is_alu || is_mov;
      unique case (jump_kind)
         JK_ALWAYS: take = is_jmp;
         JK_CARRY:  take = is_jmp && flag_q[FLAG_C];
         JK_ZERO:   take = is_jmp && flag_q[FLAG_Z];
         default:   take = 1'b0;
      endcase
      flag_d         = '0;
      flag_d[FLAG_C] = alu_carry;
      flag_d[FLAG_Z] = alu_zero;
   end

   rom_seq_ptr #(.AW(AW)) ptr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hlt_word (is_hlt),
      .take     (take),
      .target   (target),
      .ip       (rom_addr),
      .halted   (halted)
   );

   rom_seq_flags #(.NF(N_FLAGS)) flg_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (is_alu),
      .flag_d (flag_d),
      .flag_q (flag_q)
   );

   assign flag_c  = flag_q[FLAG_C];
   assign flag_z  = flag_q[FLAG_Z];
   assign alu_cin = flag_q[FLAG_C];

endmodule

// File: rtl/rom_sequencer_chk.sv
module rom_sequencer_chk #(
   parameter int unsigned IW = 8,
   parameter int unsigned AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [IW-1:0] instr,
   input logic          alu_carry,
   input logic          alu_zero,
   input logic [AW-1:0] rom_addr,
   input logic          is_alu,
   input logic          is_mov,
   input logic          is_jmp,
   input logic          is_hlt,
   input logic          reg_we,
   input logic          flag_c,
   input logic          flag_z
);

   logic [1:0] kind;
   assign kind = instr[AW +: 2];

   // R2
   class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({is_alu, is_mov, is_jmp, is_hlt}) == 1);

   // R3
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_alu || is_mov) |=> rom_addr == AW'($past(rom_addr) + 1'b1));

   // R4
   jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_jmp && kind == 2'b00) |=> rom_addr == $past(instr[AW-1:0]));

   // R5
   jump_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_jmp && kind == 2'b01 && flag_c) |=> rom_addr == $past(instr[AW-1:0]));

   // R6
   jump_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_jmp && kind == 2'b10 && flag_z) |=> rom_addr == $past(instr[AW-1:0]));

   // R7
   jump_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_jmp && kind == 2'b11) |=> rom_addr == AW'($past(rom_addr) + 1'b1));

   // R8
   flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_alu |=> (flag_c == $past(alu_carry)) && (flag_z == $past(alu_zero)));

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_alu |=> $stable(flag_c) && $stable(flag_z));

   // R11
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_hlt |=> is_hlt && $stable(rom_addr));

   // R12
   halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_hlt || is_jmp) |-> !reg_we);

endmodule

bind rom_sequencer rom_sequencer_chk #(.IW(IW), .AW(AW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .instr     (instr),
   .alu_carry (alu_carry),
   .alu_zero  (alu_zero),
   .rom_addr  (rom_addr),
   .is_alu    (is_alu),
   .is_mov    (is_mov),
   .is_jmp    (is_jmp),
   .is_hlt    (is_hlt),
   .reg_we    (reg_we),
   .flag_c    (flag_c),
   .flag_z    (flag_z)
);

// File: tb/rom_sequencer_tb_top.sv
module rom_sequencer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] instr = 8'h00;
   logic       alu_carry = 1'b0;
   logic       alu_zero = 1'b0;
   logic [3:0] rom_addr;
   logic       is_alu, is_mov, is_jmp, is_hlt, reg_we, alu_cin, flag_c, flag_z;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // expected state, kept from the requirements
   logic [3:0] m_ip;
   logic       m_c, m_z, m_halt;

   always #2.5 clk = ~clk;

   rom_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .instr(instr), .alu_carry(alu_carry), .alu_zero(alu_zero),
      .rom_addr(rom_addr), .is_alu(is_alu), .is_mov(is_mov), .is_jmp(is_jmp), .is_hlt(is_hlt),
      .reg_we(reg_we), .alu_cin(alu_cin), .flag_c(flag_c), .flag_z(flag_z)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(input logic [1:0] cls, input logic [1:0] kind,
                                     input logic [3:0] tgt);
      return {cls, kind, tgt};
   endfunction

   // applies one word at a falling edge, checks it, clocks, checks the result
   task automatic step(input logic [7:0] w, input logic c, input logic z);
      logic [1:0] cls;
      logic [1:0] kind;
      logic       tk;
      string      ptag;
      string      ftag;
      int         exp_str;
      cls  = w[7:6];
      kind = w[5:4];
      instr = w; alu_carry = c; alu_zero = z;
      #1;
      exp_str = m_halt ? 4'b0001 : (4'b1000 >> cls);
      chk({is_alu, is_mov, is_jmp, is_hlt} == exp_str[3:0], "R2 class strobes",
          {is_alu, is_mov, is_jmp, is_hlt}, exp_str);
      chk(reg_we == (!m_halt && (cls == 2'b00 || cls == 2'b01)), "R12 reg_we",
          reg_we, (!m_halt && (cls == 2'b00 || cls == 2'b01)));
      chk(alu_cin == m_c, "R10 alu_cin", alu_cin, m_c);
      tk = 1'b0;
      if (m_halt || cls == 2'b11) begin
         ptag = "R11 pointer frozen";
         ftag = "R11 flags frozen";
         m_halt = 1'b1;
      end else begin
         ftag = (cls == 2'b00) ? "R8 flag capture" : "R9 flag hold";
         if (cls == 2'b10) begin
            case (kind)
               2'b00: begin tk = 1'b1; ptag = "R4 always jump"; end
               2'b01: begin tk = m_c;  ptag = "R5 carry jump"; end
               2'b10: begin tk = m_z;  ptag = "R6 zero jump"; end
               default: begin tk = 1'b0; ptag = "R7 never jump"; end
            endcase
         end else begin
            ptag = "R3 increment";
         end
         m_ip = tk ? w[3:0] : m_ip + 4'd1;
         if (cls == 2'b00) begin
            m_c = c;
            m_z = z;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk(rom_addr == m_ip, ptag, rom_addr, m_ip);
      chk({flag_c, flag_z} == {m_c, m_z}, ftag, {flag_c, flag_z}, {m_c, m_z});
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      m_ip = 4'd0; m_c = 1'b0; m_z = 1'b0; m_halt = 1'b0;
      chk(rom_addr == 4'd0, "R1 pointer cleared", rom_addr, 0);
      chk({flag_c, flag_z} == 2'b00, "R1 flags cleared", {flag_c, flag_z}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      instr = mk(2'b00, 2'b00, 4'h0);
      #1;
      chk(is_alu && !is_hlt, "R1 halt state cleared", is_hlt, 0);
   endtask

   task automatic t_linear();
      step(mk(2'b00, 2'b11, 4'h6), 1'b1, 1'b0);
      step(mk(2'b01, 2'b00, 4'h2), 1'b0, 1'b1);
      step(mk(2'b00, 2'b00, 4'h0), 1'b0, 1'b1);
      step(mk(2'b01, 2'b10, 4'hF), 1'b1, 1'b0);
      step(mk(2'b00, 2'b01, 4'h3), 1'b0, 1'b0);
   endtask

   task automatic t_wrap();
      step(mk(2'b10, 2'b00, 4'hF), 1'b1, 1'b1);
      step(mk(2'b00, 2'b00, 4'h0), 1'b1, 1'b1);
      step(mk(2'b10, 2'b00, 4'hE), 1'b0, 1'b0);
      step(mk(2'b01, 2'b00, 4'h0), 1'b0, 1'b0);
      step(mk(2'b01, 2'b00, 4'h0), 1'b0, 1'b0);
   endtask

   task automatic t_cond();
      step(mk(2'b00, 2'b00, 4'h0), 1'b1, 1'b0);
      step(mk(2'b10, 2'b01, 4'h9), 1'b0, 1'b1);
      step(mk(2'b10, 2'b10, 4'h2), 1'b0, 1'b1);
      step(mk(2'b00, 2'b00, 4'h0), 1'b0, 1'b1);
      step(mk(2'b10, 2'b10, 4'h2), 1'b1, 1'b0);
      step(mk(2'b10, 2'b01, 4'h7), 1'b1, 1'b0);
      step(mk(2'b00, 2'b00, 4'h0), 1'b1, 1'b1);
      step(mk(2'b10, 2'b11, 4'h5), 1'b0, 1'b0);
   endtask

   task automatic t_halt();
      step(mk(2'b00, 2'b00, 4'h0), 1'b0, 1'b0);
      step(mk(2'b11, 2'b00, 4'h4), 1'b1, 1'b1);
      step(mk(2'b00, 2'b00, 4'h0), 1'b1, 1'b1);
      step(mk(2'b10, 2'b00, 4'h3), 1'b0, 1'b0);
      step(mk(2'b01, 2'b00, 4'h0), 1'b1, 1'b0);
      t_reset();
      step(mk(2'b00, 2'b00, 4'h0), 1'b1, 1'b0);
      step(mk(2'b01, 2'b00, 4'h0), 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin : main
      m_ip = 4'd0; m_c = 1'b0; m_z = 1'b0; m_halt = 1'b0;
      repeat (2) @(negedge clk);
      t_reset();
      t_linear();
      t_wrap();
      t_cond();
      t_reset();
      t_halt();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule